// File: doc/BRIEF.md
# EEPROM Address Pointer and Page Latch

This block holds the internal byte pointer of a serial EEPROM and gathers the bytes of a page write before they go to storage. The bus front end passes it the two address bytes as strobes. It also passes each accepted write byte over a valid/ready stream and pulses a step request after each byte read out. A pulse on `commit_req` starts the program cycle. The block then offers the filled row, a per-byte enable mask and the row number to storage on a second valid/ready stream.

The pointer steps differently in each access kind. A page write steps only the in-row lane, so bytes past the row end wrap to the row start and overwrite earlier ones. A main-array read steps the whole pointer and rolls over from the top address to zero. A read of the 32-byte one-time page presents only the low five pointer bits, so it wraps within the page. The full pointer still advances during that read, so a later main-array current read continues at the byte after the last one accessed.

The storage stream uses these back-pressure rules. `cm_valid` stays high, with row, data and mask frozen, until the cycle in which `cm_ready` is high. While an offer is pending, `wr_ready` is low and the write stream is stalled. Bus signalling and protection decisions belong to other blocks.

Top module: `eep_ptr_latch`

## Requirements
- R1: After reset, `mem_addr` is 0, `cm_valid` is 0 and `wr_ready` is 1.
- R2: `hi_stb` records `addr_byte[3:0]` as pointer bits 11:8 and ignores `addr_byte[7:4]`. It does not move the pointer. A following `lo_stb` loads the pointer with {recorded bits, `addr_byte`}, and that value is visible on `mem_addr` in the next cycle.
- R3: Each accepted write byte (`wr_valid && wr_ready`) is stored in lane `pointer[4:0]`. Only pointer bits 4:0 then increment, wrapping 31 to 0, and bits 11:5 stay fixed. When a lane is written twice, the later byte wins.
- R4: Each accepted write byte sets its lane's bit in the enable mask. A `lo_stb` while no offer is pending clears the mask and refills every lane with 0xFF.
- R5: When `commit_req` is pulsed and the mask is not empty, `cm_valid` rises in the next cycle. `cm_row` then equals pointer bits 11:5, lane i appears on `cm_data[8i+7:8i]` and its enable on `cm_mask[i]`, and lanes never written read 0xFF. When `commit_req` is pulsed with an empty mask, nothing is offered.
- R6: While `cm_valid` is high and `cm_ready` is low, `cm_row`, `cm_data` and `cm_mask` hold, `wr_ready` is 0 and write bytes are not taken. After the cycle with `cm_ready` high, `cm_valid` and the mask are 0 and `wr_ready` is 1.
- R7: With `sel_otp` = 0, `rd_next` increments the whole 12-bit pointer, and 0xFFF rolls to 0x000.
- R8: With `sel_otp` = 1, `mem_addr` is {0, pointer[4:0]}, so reads wrap from 0x1F to 0x00. The full pointer still increments, so after one-time byte 31 a main-array access starts at 0x020.
- R9: `lo_stb` takes precedence over a write byte and over `rd_next` in the same cycle, and the write byte is dropped. An accepted write byte takes precedence over `rd_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_otp | input | 1 | Access targets the one-time page |
| hi_stb | input | 1 | Upper address byte acknowledged |
| lo_stb | input | 1 | Lower address byte acknowledged; loads pointer |
| addr_byte | input | 8 | Address byte value |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken |
| wr_data | input | 8 | Write byte value |
| rd_next | input | 1 | One byte was read out; step pointer |
| commit_req | input | 1 | Program cycle starts |
| cm_valid | output | 1 | Row offered to storage |
| cm_ready | input | 1 | Storage takes the row |
| cm_row | output | 7 | Row number (pointer bits 11:5) |
| cm_data | output | 256 | Row bytes, lane i at bits 8i+7:8i |
| cm_mask | output | 32 | Byte enables, bit i for lane i |
| mem_addr | output | 12 | Current byte address for storage |

## Verification
The page path is tried with three patterns. A short write that straddles the row end separates in-row wrapping from full-pointer stepping. A 33-byte write separates overwrite-in-place from an overflow. A write after an address reload shows whether the mask from the earlier write was cleared. The read path is driven across the top of the array and across the end of the one-time page, which tells full rollover apart from the 32-byte window and from the carry of the hidden pointer. Same-cycle collisions of a load, a write byte and a read step fix the priority order.

// File: rtl/eep_ptr_pkg.sv
package eep_ptr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    STEP_HOLD,
    STEP_LOAD,
    STEP_ROW,
    STEP_FULL
  } ptr_step_e;
endpackage

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr
  import eep_ptr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptr_step_e         step,
  input  logic              hi_stb,
  input  logic [7:0]        addr_byte,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hi_q;

  // upper address bits wait here until the lower byte is acknowledged
  always_ff @(posedge clk) begin
    if (!rst_n)      hi_q <= '0;
    else if (hi_stb) hi_q <= addr_byte[HI_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      case (step)
        STEP_LOAD: ptr_q <= {hi_q, addr_byte};
        STEP_ROW:  ptr_q[LANE_W-1:0] <= ptr_q[LANE_W-1:0] + LANE_W'(1);
        STEP_FULL: ptr_q <= ptr_q + ADDR_W'(1);
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/eep_row_latch.sv
module eep_row_latch
  import eep_ptr_pkg::*;
#(
  parameter int ROW_BYTES = 32,
  parameter int LANE_W    = 5,
  parameter int ROW_W     = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_fire,
  input  logic [LANE_W-1:0]           wr_lane,
  input  logic [BYTE_W-1:0]           wr_data,
  input  logic                        new_write,
  input  logic                        commit_req,
  input  logic [ROW_W-1:0]            row_in,
  input  logic                        cm_ready,
  output logic                        cm_valid,
  output logic [ROW_W-1:0]            cm_row,
  output logic [ROW_BYTES*BYTE_W-1:0] cm_data,
  output logic [ROW_BYTES-1:0]        cm_mask
);
  logic launch, taken, wipe;
  logic [BYTE_W-1:0] lane_q [ROW_BYTES];
  logic              en_q   [ROW_BYTES];

  assign launch = commit_req && !cm_valid && (|cm_mask);
  assign taken  = cm_valid && cm_ready;
  assign wipe   = taken || (new_write && !cm_valid);

  always_ff @(posedge clk) begin
    if (!rst_n)      cm_valid <= 1'b0;
    else if (launch) cm_valid <= 1'b1;
    else if (taken)  cm_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cm_row <= '0;
    else if (launch) cm_row <= row_in;
  end

  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
        lane_q[i] <= ERASED_BYTE;
        en_q[i]   <= 1'b0;
      end else if (wr_fire && wr_lane == LANE_W'(i)) begin
        lane_q[i] <= wr_data;
        en_q[i]   <= 1'b1;
      end
    end
    assign cm_data[i*BYTE_W +: BYTE_W] = lane_q[i];
    assign cm_mask[i]                  = en_q[i];
  end
endmodule

// File: rtl/eep_ptr_latch.sv
module eep_ptr_latch
  import eep_ptr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ROW_BYTES = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sel_otp,
  input  logic                                hi_stb,
  input  logic                                lo_stb,
  input  logic [7:0]                          addr_byte,
  input  logic                                wr_valid,
  output logic                                wr_ready,
  input  logic [7:0]                          wr_data,
  input  logic                                rd_next,
  input  logic                                commit_req,
  output logic                                cm_valid,
  input  logic                                cm_ready,
  output logic [ADDR_W-$clog2(ROW_BYTES)-1:0] cm_row,
  output logic [ROW_BYTES*8-1:0]              cm_data,
  output logic [ROW_BYTES-1:0]                cm_mask,
  output logic [ADDR_W-1:0]                   mem_addr
);
  localparam int LANE_W = $clog2(ROW_BYTES);
  localparam int ROW_W  = ADDR_W - LANE_W;

  logic [ADDR_W-1:0] ptr_q;
  logic              wr_fire;
  ptr_step_e         step;

  assign wr_ready = !cm_valid;
  assign wr_fire  = wr_valid && wr_ready && !lo_stb;

  always_comb begin
    if (lo_stb)       step = STEP_LOAD;
    else if (wr_fire) step = STEP_ROW;
    else if (rd_next) step = STEP_FULL;
    else              step = STEP_HOLD;
  end

  // the one-time page only sees the in-row lane; the full pointer keeps counting
  assign mem_addr = sel_otp ? {{ROW_W{1'b0}}, ptr_q[LANE_W-1:0]} : ptr_q;

  eep_addr_ptr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .hi_stb    (hi_stb),
    .addr_byte (addr_byte),
    .ptr_q     (ptr_q)
  );

  eep_row_latch #(.ROW_BYTES(ROW_BYTES), .LANE_W(LANE_W), .ROW_W(ROW_W)) u_row (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_lane    (ptr_q[LANE_W-1:0]),
    .wr_data    (wr_data),
    .new_write  (lo_stb),
    .commit_req (commit_req),
    .row_in     (ptr_q[ADDR_W-1:LANE_W]),
    .cm_ready   (cm_ready),
    .cm_valid   (cm_valid),
    .cm_row     (cm_row),
    .cm_data    (cm_data),
    .cm_mask    (cm_mask)
  );
endmodule

// File: rtl/eep_ptr_latch_chk.sv
module eep_ptr_latch_chk #(
  parameter int ADDR_W    = 12,
  parameter int ROW_BYTES = 32
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                sel_otp,
  input logic                                lo_stb,
  input logic                                wr_valid,
  input logic                                wr_ready,
  input logic                                rd_next,
  input logic                                cm_valid,
  input logic                                cm_ready,
  input logic [ADDR_W-$clog2(ROW_BYTES)-1:0] cm_row,
  input logic [ROW_BYTES*8-1:0]              cm_data,
  input logic [ROW_BYTES-1:0]                cm_mask,
  input logic [ADDR_W-1:0]                   mem_addr
);
  localparam int LW = $clog2(ROW_BYTES);

  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_ready |=> cm_valid && $stable(cm_row) && $stable(cm_data) && $stable(cm_mask));

  // R5
  offer_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> cm_mask != '0);

  // R6
  stall_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !lo_stb && !rd_next |=> !$stable(sel_otp) || $stable(mem_addr));

  // R3
  row_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !lo_stb && !sel_otp |=>
      sel_otp || mem_addr[ADDR_W-1:LW] == $past(mem_addr[ADDR_W-1:LW]));

  // R7
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next && !lo_stb && !(wr_valid && wr_ready) && !sel_otp |=>
      sel_otp || mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1)));

  // R8
  otp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_otp |-> mem_addr[ADDR_W-1:LW] == '0);
endmodule

bind eep_ptr_latch eep_ptr_latch_chk #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_otp  (sel_otp),
  .lo_stb   (lo_stb),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .rd_next  (rd_next),
  .cm_valid (cm_valid),
  .cm_ready (cm_ready),
  .cm_row   (cm_row),
  .cm_data  (cm_data),
  .cm_mask  (cm_mask),
  .mem_addr (mem_addr)
);

// File: tb/eep_ptr_latch_tb.sv
module eep_ptr_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_otp = 1'b0, hi_stb = 1'b0, lo_stb = 1'b0;
  logic [7:0]   addr_byte = '0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [7:0]   wr_data = '0;
  logic         rd_next = 1'b0, commit_req = 1'b0, cm_ready = 1'b0;
  logic         cm_valid;
  logic [6:0]   cm_row;
  logic [255:0] cm_data;
  logic [31:0]  cm_mask;
  logic [11:0]  mem_addr;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eep_ptr_latch u_dut (
    .clk(clk), .rst_n(rst_n), .sel_otp(sel_otp), .hi_stb(hi_stb), .lo_stb(lo_stb),
    .addr_byte(addr_byte), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_next(rd_next), .commit_req(commit_req), .cm_valid(cm_valid), .cm_ready(cm_ready),
    .cm_row(cm_row), .cm_data(cm_data), .cm_mask(cm_mask), .mem_addr(mem_addr)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_addr(input logic [15:0] a);
    hi_stb = 1'b1; addr_byte = a[15:8]; tick();
    hi_stb = 1'b0; lo_stb = 1'b1; addr_byte = a[7:0]; tick();
    lo_stb = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d; tick();
    wr_valid = 1'b0;
  endtask

  task automatic commit();
    commit_req = 1'b1; tick();
    commit_req = 1'b0;
  endtask

  task automatic take();
    cm_ready = 1'b1; tick();
    cm_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 mem_addr", 256'(mem_addr), 256'h0);
    check("R1 cm_valid", 256'(cm_valid), 256'h0);
    check("R1 wr_ready", 256'(wr_ready), 256'h1);
  endtask

  task automatic t_page_wrap();
    load_addr(16'h23FE);
    check("R2 load ignores upper nibble", 256'(mem_addr), 256'h3FE);
    push(8'hAA); push(8'hBB); push(8'hCC); push(8'hDD);
    check("R3 lane wrap keeps row", 256'(mem_addr), 256'h3E2);
    commit();
    check("R5 offer raised", 256'(cm_valid), 256'h1);
    check("R5 row", 256'(cm_row), 256'd31);
    check("R5 mask", 256'(cm_mask), 256'hC000_0003);
    check("R5 lane30", 256'(cm_data[30*8 +: 8]), 256'hAA);
    check("R5 lane31", 256'(cm_data[31*8 +: 8]), 256'hBB);
    check("R5 lane0", 256'(cm_data[0 +: 8]), 256'hCC);
    check("R5 lane1", 256'(cm_data[8 +: 8]), 256'hDD);
    check("R5 unwritten lane erased", 256'(cm_data[5*8 +: 8]), 256'hFF);
    check("R6 wr_ready low", 256'(wr_ready), 256'h0);
    wr_valid = 1'b1; wr_data = 8'h55;
    for (int k = 0; k < 3; k++) tick();
    wr_valid = 1'b0;
    check("R6 stalled pointer", 256'(mem_addr), 256'h3E2);
    check("R6 stalled mask", 256'(cm_mask), 256'hC000_0003);
    check("R6 stalled lane2", 256'(cm_data[2*8 +: 8]), 256'hFF);
    check("R6 still offered", 256'(cm_valid), 256'h1);
    take();
    check("R6 offer dropped", 256'(cm_valid), 256'h0);
    check("R6 mask cleared", 256'(cm_mask), 256'h0);
    check("R6 ready again", 256'(wr_ready), 256'h1);
  endtask

  task automatic t_overwrite();
    load_addr(16'h0040);
    for (int i = 0; i < 33; i++) push(8'(i + 1));
    check("R3 pointer after 33", 256'(mem_addr), 256'h041);
    commit();
    check("R3 full mask", 256'(cm_mask), 256'hFFFF_FFFF);
    check("R3 lane0 overwritten", 256'(cm_data[0 +: 8]), 256'h21);
    check("R3 lane1", 256'(cm_data[8 +: 8]), 256'h02);
    check("R3 lane31", 256'(cm_data[31*8 +: 8]), 256'h20);
    check("R5 row 2", 256'(cm_row), 256'd2);
    take();
  endtask

  task automatic t_mask_clear();
    load_addr(16'h0105);
    push(8'h11);
    load_addr(16'h0100);
    push(8'h22);
    commit();
    check("R4 mask only new lane", 256'(cm_mask), 256'h1);
    check("R4 old lane refilled", 256'(cm_data[5*8 +: 8]), 256'hFF);
    check("R4 new lane", 256'(cm_data[0 +: 8]), 256'h22);
    take();
  endtask

  task automatic t_empty_commit();
    load_addr(16'h0200);
    commit();
    check("R5 empty commit no offer", 256'(cm_valid), 256'h0);
  endtask

  task automatic t_read_roll();
    load_addr(16'h0FFF);
    rd_next = 1'b1; tick();
    check("R7 rollover", 256'(mem_addr), 256'h000);
    tick(); rd_next = 1'b0;
    check("R7 step", 256'(mem_addr), 256'h001);
  endtask

  task automatic t_otp();
    sel_otp = 1'b1;
    load_addr(16'h00A3);
    check("R8 window", 256'(mem_addr), 256'h003);
    load_addr(16'h001E);
    rd_next = 1'b1; tick();
    check("R8 byte 31", 256'(mem_addr), 256'h01F);
    tick(); rd_next = 1'b0;
    check("R8 wrap to 0", 256'(mem_addr), 256'h000);
    sel_otp = 1'b0; #1;
    check("R8 carry into array", 256'(mem_addr), 256'h020);
  endtask

  task automatic t_priority();
    hi_stb = 1'b1; addr_byte = 8'h05; tick();
    hi_stb = 1'b0;
    lo_stb = 1'b1; addr_byte = 8'h10; wr_valid = 1'b1; wr_data = 8'h77; rd_next = 1'b1; tick();
    lo_stb = 1'b0; wr_valid = 1'b0; rd_next = 1'b0;
    check("R9 load wins", 256'(mem_addr), 256'h510);
    load_addr(16'h051F);
    wr_valid = 1'b1; wr_data = 8'h99; rd_next = 1'b1; tick();
    wr_valid = 1'b0; rd_next = 1'b0;
    check("R9 write over read", 256'(mem_addr), 256'h500);
    commit();
    check("R9 dropped byte absent", 256'(cm_mask), 256'h8000_0000);
    check("R9 lane31", 256'(cm_data[31*8 +: 8]), 256'h99);
    take();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_page_wrap();
    t_overwrite();
    t_mask_clear();
    t_empty_commit();
    t_read_roll();
    t_otp();
    t_priority();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule